// File: doc/BRIEF.md
# Segment Descriptor Cache (direct-mapped)

This block keeps recently used two-word segment descriptors for a segmented, paged address translator. A lookup port takes a 32-bit virtual address. It returns a hit flag and the two stored words of the slot that the address selects. A fill port writes a descriptor into that same slot, so the walker that fetched it from memory can cache it. Descriptor fetch and access-permission checks belong to the surrounding translator.

The entry slot comes from two address fields: the two section-number bits va[31:30] and the three segment-select bits va[19:17] just below the tag. The tag is va[31:20]. Every entry can be invalidated in three ways:

- by section, when software rewrites a section base;
- by a single address, when software writes the virtual address register;
- globally.

Every entry's low and high words can also be read and written through a word-addressed register port. Lookup and register reads are combinational. All state changes take effect at the rising clock edge.

Top module: `sdc_cache`

## Requirements
- R1: After reset every entry's low and high words read as zero, and no lookup hits.
- R2: The entry index is {va[31:30], va[19:17]}. The register address selects a word with bits [11:8] (0 = low word, 1 = high word) and the entry with bits [6:2].
- R3: A fill writes the low word as {fill_lo[31:12], va[31:20]} and the high word as fill_hi with bit 0 forced to 1.
- R4: A lookup hits only when bit 0 (valid) of the entry's high word is set and the entry's low word bits [11:0] equal va[31:20]. The entry's words appear on the lookup outputs whether or not it hits.
- R5: A section invalidate clears high-word bit 0 of every entry whose low word bits [11:10] equal the given section number. All other bits, and all entries of other sections, stay unchanged.
- R6: An address invalidate clears the valid bit only of the entry at that address's index, and only if the entry's stored tag equals the address's bits [31:20].
- R7: A global flush clears the valid bit of every entry.
- R8: A fill and an invalidate that reach the same entry in the same cycle leave the entry valid with the filled words.
- R9: A register write replaces the selected word at the next edge, and it overrides a fill or invalidate of that word in the same cycle. Entity codes other than 0 and 1 read as zero and their writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_lo | output | 32 | Low word of the selected entry |
| lk_hi | output | 32 | High word of the selected entry |
| fill_en | input | 1 | Write a descriptor into the slot of fill_va |
| fill_va | input | 32 | Fill virtual address |
| fill_lo | input | 32 | Descriptor low word (bits [31:12] kept) |
| fill_hi | input | 32 | Descriptor high word (bit 0 replaced by valid) |
| sec_inv_en | input | 1 | Invalidate one section |
| sec_inv_num | input | 2 | Section to invalidate |
| va_inv_en | input | 1 | Invalidate by address |
| va_inv_addr | input | 32 | Address for the address invalidate |
| flush_all | input | 1 | Invalidate every entry |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write when set, read otherwise |
| reg_addr | input | 12 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
Lookups are tried with four kinds of address: the exact filled address, an address with the same slot but a different tag, an address in another slot, and an address in a different section. These separate tag compare from index selection. Invalidates are tried against a matching entry and a near-miss, which shows each rule removes only its own targets:

- section invalidate: one section against a neighbouring section;
- address invalidate: a matching tag against a mismatching tag at the same slot.

Same-cycle collisions are also driven: a fill against a flush, and a register write against a flush. These expose the precedence order. Register read-back shows the stored words bit for bit, and an unused entity code shows that writes to it go nowhere.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   // entity codes seen in the register address entity field
   typedef enum logic [3:0] {
      ENT_LOW  = 4'h0,
      ENT_HIGH = 4'h1
   } sdc_ent_e;
endpackage

// File: rtl/sdc_index.sv
module sdc_index #(
   parameter int VA_W  = 32,
   parameter int TAG_W = 12,
   parameter int SEC_W = 2,
   parameter int SET_W = 3
) (
   input  logic [VA_W-1:0]        va,
   output logic [SEC_W+SET_W-1:0] idx,
   output logic [TAG_W-1:0]       tag
);
   localparam int SEG_LSB = VA_W - TAG_W - SET_W;

   logic unused_va_low;

   assign tag = va[VA_W-1 -: TAG_W];
   assign idx = {va[VA_W-1 -: SEC_W], va[SEG_LSB +: SET_W]};
   assign unused_va_low = ^va[SEG_LSB-1:0];
endmodule

// File: rtl/sdc_entry.sv
module sdc_entry #(
   parameter int WORD_W  = 32,
   parameter int TAG_W   = 12,
   parameter int SEC_W   = 2,
   parameter int VAL_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_all,
   input  logic              sec_inv_en,
   input  logic [SEC_W-1:0]  sec_inv_num,
   input  logic              va_inv_sel,
   input  logic [TAG_W-1:0]  va_inv_tag,
   input  logic              fill_sel,
   input  logic [WORD_W-1:0] fill_lo_word,
   input  logic [WORD_W-1:0] fill_hi_word,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] lo_q,
   output logic [WORD_W-1:0] hi_q
);
   logic              kill;
   logic [WORD_W-1:0] lo_d, hi_d;

   always_comb begin
      kill = flush_all
           | (sec_inv_en && (lo_q[TAG_W-1 -: SEC_W] == sec_inv_num))
           | (va_inv_sel && (lo_q[TAG_W-1:0] == va_inv_tag));
   end

   // later steps win: invalidate, then fill, then register write
   always_comb begin
      lo_d = lo_q;
      hi_d = hi_q;
      if (kill) hi_d[VAL_BIT] = 1'b0;
      if (fill_sel) begin
         lo_d = fill_lo_word;
         hi_d = fill_hi_word;
      end
      if (wr_lo) lo_d = wdata;
      if (wr_hi) hi_d = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end
endmodule

// File: rtl/sdc_regport.sv
module sdc_regport import sdc_pkg::*; #(
   parameter int WORD_W  = 32,
   parameter int IDX_W   = 5,
   parameter int RA_W    = 12,
   parameter int ENT_W   = 4,
   parameter int ENTRIES = 32
) (
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [WORD_W-1:0] lo_q [ENTRIES],
   input  logic [WORD_W-1:0] hi_q [ENTRIES],
   output logic [ENTRIES-1:0] wr_lo,
   output logic [ENTRIES-1:0] wr_hi,
   output logic [WORD_W-1:0] reg_rdata
);
   localparam int IDX_LSB = 2;
   localparam int ENT_LSB = RA_W - ENT_W;

   logic [ENT_W-1:0] ent;
   logic [IDX_W-1:0] sel;
   logic             is_lo, is_hi;
   logic             unused_addr;

   assign ent   = reg_addr[ENT_LSB +: ENT_W];
   assign sel   = reg_addr[IDX_LSB +: IDX_W];
   assign is_lo = (ent == ENT_W'(ENT_LOW));
   assign is_hi = (ent == ENT_W'(ENT_HIGH));
   assign unused_addr = ^{reg_addr[IDX_LSB-1:0], reg_addr[ENT_LSB-1:IDX_LSB+IDX_W]};

   for (genvar i = 0; i < ENTRIES; i++) begin : g_dec
      assign wr_lo[i] = reg_en && reg_we && is_lo && (sel == IDX_W'(i));
      assign wr_hi[i] = reg_en && reg_we && is_hi && (sel == IDX_W'(i));
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_en && !reg_we) begin
         if (is_lo) reg_rdata = lo_q[sel];
         else if (is_hi) reg_rdata = hi_q[sel];
      end
   end
endmodule

// File: rtl/sdc_lookup.sv
module sdc_lookup #(
   parameter int WORD_W  = 32,
   parameter int TAG_W   = 12,
   parameter int IDX_W   = 5,
   parameter int ENTRIES = 32,
   parameter int VAL_BIT = 0
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [TAG_W-1:0]  tag,
   input  logic [WORD_W-1:0] lo_q [ENTRIES],
   input  logic [WORD_W-1:0] hi_q [ENTRIES],
   output logic              hit,
   output logic [WORD_W-1:0] lo,
   output logic [WORD_W-1:0] hi
);
   assign lo  = lo_q[idx];
   assign hi  = hi_q[idx];
   assign hit = hi[VAL_BIT] && (lo[TAG_W-1:0] == tag);
endmodule

// File: rtl/sdc_cache.sv
module sdc_cache #(
   parameter int VA_W    = 32,
   parameter int WORD_W  = 32,
   parameter int TAG_W   = 12,
   parameter int SEC_W   = 2,
   parameter int SET_W   = 3,
   parameter int RA_W    = 12,
   parameter int ENT_W   = 4,
   parameter int VAL_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VA_W-1:0]   lk_va,
   output logic              lk_hit,
   output logic [WORD_W-1:0] lk_lo,
   output logic [WORD_W-1:0] lk_hi,
   input  logic              fill_en,
   input  logic [VA_W-1:0]   fill_va,
   input  logic [WORD_W-1:0] fill_lo,
   input  logic [WORD_W-1:0] fill_hi,
   input  logic              sec_inv_en,
   input  logic [SEC_W-1:0]  sec_inv_num,
   input  logic              va_inv_en,
   input  logic [VA_W-1:0]   va_inv_addr,
   input  logic              flush_all,
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata
);
   localparam int IDX_W   = SEC_W + SET_W;
   localparam int ENTRIES = 1 << IDX_W;

   initial begin
      assert (TAG_W > SEC_W && TAG_W < WORD_W)
         else $error("sdc_cache: tag must hold the section bits and fit a word");
      assert (TAG_W + SET_W < VA_W)
         else $error("sdc_cache: tag and set bits exceed the address");
      assert (VAL_BIT >= 0 && VAL_BIT < WORD_W)
         else $error("sdc_cache: valid bit outside the word");
      assert (2 + IDX_W <= RA_W - ENT_W)
         else $error("sdc_cache: register address too narrow");
   end

   logic [WORD_W-1:0] lo_q [ENTRIES];
   logic [WORD_W-1:0] hi_q [ENTRIES];
   logic [ENTRIES-1:0] wr_lo, wr_hi;

   logic [IDX_W-1:0] lk_idx, fill_idx, vi_idx;
   logic [TAG_W-1:0] lk_tag, fill_tag, vi_tag;
   logic [WORD_W-1:0] fill_lo_word, fill_hi_word;
   logic unused_fill_lo;

   sdc_index #(.VA_W(VA_W), .TAG_W(TAG_W), .SEC_W(SEC_W), .SET_W(SET_W))
      u_idx_lk (.va(lk_va), .idx(lk_idx), .tag(lk_tag));
   sdc_index #(.VA_W(VA_W), .TAG_W(TAG_W), .SEC_W(SEC_W), .SET_W(SET_W))
      u_idx_fill (.va(fill_va), .idx(fill_idx), .tag(fill_tag));
   sdc_index #(.VA_W(VA_W), .TAG_W(TAG_W), .SEC_W(SEC_W), .SET_W(SET_W))
      u_idx_vi (.va(va_inv_addr), .idx(vi_idx), .tag(vi_tag));

   assign fill_lo_word   = {fill_lo[WORD_W-1:TAG_W], fill_tag};
   assign fill_hi_word   = fill_hi | (WORD_W'(1) << VAL_BIT);
   assign unused_fill_lo = ^fill_lo[TAG_W-1:0];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      sdc_entry #(.WORD_W(WORD_W), .TAG_W(TAG_W), .SEC_W(SEC_W), .VAL_BIT(VAL_BIT)) u_ent (
         .clk          (clk),
         .rst_n        (rst_n),
         .flush_all    (flush_all),
         .sec_inv_en   (sec_inv_en),
         .sec_inv_num  (sec_inv_num),
         .va_inv_sel   (va_inv_en && (vi_idx == IDX_W'(i))),
         .va_inv_tag   (vi_tag),
         .fill_sel     (fill_en && (fill_idx == IDX_W'(i))),
         .fill_lo_word (fill_lo_word),
         .fill_hi_word (fill_hi_word),
         .wr_lo        (wr_lo[i]),
         .wr_hi        (wr_hi[i]),
         .wdata        (reg_wdata),
         .lo_q         (lo_q[i]),
         .hi_q         (hi_q[i])
      );
   end

   sdc_regport #(.WORD_W(WORD_W), .IDX_W(IDX_W), .RA_W(RA_W), .ENT_W(ENT_W), .ENTRIES(ENTRIES))
      u_reg (
         .reg_en    (reg_en),
         .reg_we    (reg_we),
         .reg_addr  (reg_addr),
         .lo_q      (lo_q),
         .hi_q      (hi_q),
         .wr_lo     (wr_lo),
         .wr_hi     (wr_hi),
         .reg_rdata (reg_rdata)
      );

   sdc_lookup #(.WORD_W(WORD_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .ENTRIES(ENTRIES), .VAL_BIT(VAL_BIT))
      u_lk (
         .idx  (lk_idx),
         .tag  (lk_tag),
         .lo_q (lo_q),
         .hi_q (hi_q),
         .hit  (lk_hit),
         .lo   (lk_lo),
         .hi   (lk_hi)
      );
endmodule

// File: rtl/sdc_cache_chk.sv
module sdc_cache_chk #(
   parameter int VA_W    = 32,
   parameter int WORD_W  = 32,
   parameter int TAG_W   = 12,
   parameter int SEC_W   = 2,
   parameter int SET_W   = 3,
   parameter int VAL_BIT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [VA_W-1:0]   lk_va,
   input logic              lk_hit,
   input logic [WORD_W-1:0] lk_lo,
   input logic [WORD_W-1:0] lk_hi,
   input logic              fill_en,
   input logic [VA_W-1:0]   fill_va,
   input logic              sec_inv_en,
   input logic [SEC_W-1:0]  sec_inv_num,
   input logic              flush_all,
   input logic              reg_en,
   input logic              reg_we,
   input logic [WORD_W-1:0] lo_q [1 << (SEC_W+SET_W)],
   input logic [WORD_W-1:0] hi_q [1 << (SEC_W+SET_W)]
);
   localparam int IDX_W   = SEC_W + SET_W;
   localparam int ENTRIES = 1 << IDX_W;
   localparam int SEG_LSB = VA_W - TAG_W - SET_W;

   logic [ENTRIES-1:0] g_vec, sec_hit, sec_mask_q;
   logic [IDX_W-1:0]   fill_slot;
   logic               reg_wr;

   assign reg_wr    = reg_en && reg_we;
   assign fill_slot = {fill_va[VA_W-1 -: SEC_W], fill_va[SEG_LSB +: SET_W]};

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         g_vec[i]   = hi_q[i][VAL_BIT];
         sec_hit[i] = (lo_q[i][TAG_W-1 -: SEC_W] == sec_inv_num);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sec_mask_q <= '0;
      else if (sec_inv_en && !fill_en && !reg_wr) sec_mask_q <= sec_hit;
      else sec_mask_q <= '0;
   end

   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_hi[VAL_BIT]); // R4
   AST_HIT_TAG_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_lo[TAG_W-1:0] == lk_va[VA_W-1 -: TAG_W])); // R4
   AST_FLUSH_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all && !fill_en && !reg_wr) |=> (g_vec == '0)); // R7
   AST_FILL_LEAVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !reg_wr) |=> g_vec[$past(fill_slot)]); // R8
   AST_SECTION_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ((sec_mask_q & g_vec) == '0)); // R5
endmodule

bind sdc_cache sdc_cache_chk #(
   .VA_W(VA_W), .WORD_W(WORD_W), .TAG_W(TAG_W), .SEC_W(SEC_W), .SET_W(SET_W), .VAL_BIT(VAL_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_va       (lk_va),
   .lk_hit      (lk_hit),
   .lk_lo       (lk_lo),
   .lk_hi       (lk_hi),
   .fill_en     (fill_en),
   .fill_va     (fill_va),
   .sec_inv_en  (sec_inv_en),
   .sec_inv_num (sec_inv_num),
   .flush_all   (flush_all),
   .reg_en      (reg_en),
   .reg_we      (reg_we),
   .lo_q        (lo_q),
   .hi_q        (hi_q)
);

// File: tb/sdc_cache_test.sv
module sdc_cache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_va = '0;
   logic        lk_hit;
   logic [31:0] lk_lo, lk_hi;
   logic        fill_en = 1'b0;
   logic [31:0] fill_va = '0, fill_lo = '0, fill_hi = '0;
   logic        sec_inv_en = 1'b0;
   logic [1:0]  sec_inv_num = '0;
   logic        va_inv_en = 1'b0;
   logic [31:0] va_inv_addr = '0;
   logic        flush_all = 1'b0;
   logic        reg_en = 1'b0, reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   localparam logic [31:0] VA_A  = 32'h4012_0000; // slot 9, tag 401, section 1
   localparam logic [31:0] VA_A2 = 32'h4212_0000; // slot 9, tag 421
   localparam logic [31:0] VA_B  = 32'h8004_0000; // slot 18, tag 800, section 2

   always #2.5 clk = ~clk;

   sdc_cache uut (.*);

   function automatic logic [4:0] slot_of(logic [31:0] va);
      return {va[31:30], va[19:17]}; // R2
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic look(logic [31:0] va);
      lk_va = va;
      #0.5;
   endtask

   task automatic rd(logic [3:0] ent, logic [4:0] idx, output logic [31:0] d);
      reg_en = 1'b1; reg_we = 1'b0;
      reg_addr = {ent, 1'b0, idx, 2'b00};
      #0.5;
      d = reg_rdata;
      reg_en = 1'b0;
   endtask

   task automatic wr(logic [3:0] ent, logic [4:0] idx, logic [31:0] d);
      reg_en = 1'b1; reg_we = 1'b1;
      reg_addr = {ent, 1'b0, idx, 2'b00};
      reg_wdata = d;
      tick();
      reg_en = 1'b0; reg_we = 1'b0;
   endtask

   task automatic fill(logic [31:0] va, logic [31:0] lo, logic [31:0] hi);
      fill_en = 1'b1; fill_va = va; fill_lo = lo; fill_hi = hi;
      tick();
      fill_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      int bad = 0;
      for (int i = 0; i < 32; i++) begin
         rd(4'h0, 5'(i), d); if (d !== 0) bad++;
         rd(4'h1, 5'(i), d); if (d !== 0) bad++;
      end
      chk("R1 words zero after reset", 32'(bad), 0);
      look(32'h0000_0000);
      chk("R1 no hit after reset", 32'(lk_hit), 0);
   endtask

   task automatic t_fill_hit();
      logic [31:0] d;
      fill(VA_A, 32'hABCD_EFFF, 32'h1234_5670);
      look(VA_A);
      chk("R4 hit on filled address", 32'(lk_hit), 1);
      chk("R3 lookup low word", lk_lo, 32'hABCD_E401);
      chk("R3 lookup high word", lk_hi, 32'h1234_5671);
      look(VA_A2);
      chk("R4 same slot other tag misses", 32'(lk_hit), 0);
      chk("R4 words shown on miss", lk_lo, 32'hABCD_E401);
      look(VA_B);
      chk("R4 other slot misses", 32'(lk_hit), 0);
      rd(4'h0, slot_of(VA_A), d);
      chk("R2 low word at computed slot", d, 32'hABCD_E401);
      rd(4'h1, slot_of(VA_A), d);
      chk("R2 high word at computed slot", d, 32'h1234_5671);
   endtask

   task automatic t_section();
      logic [31:0] d;
      fill(VA_A, 32'h1111_1000, 32'h2222_2220);
      fill(VA_B, 32'h3333_3000, 32'h4444_4440);
      sec_inv_en = 1'b1; sec_inv_num = 2'd1;
      tick();
      sec_inv_en = 1'b0;
      look(VA_A);
      chk("R5 section 1 entry invalidated", 32'(lk_hit), 0);
      look(VA_B);
      chk("R5 section 2 entry kept", 32'(lk_hit), 1);
      rd(4'h1, slot_of(VA_A), d);
      chk("R5 only valid bit cleared (high)", d, 32'h2222_2220);
      rd(4'h0, slot_of(VA_A), d);
      chk("R5 low word untouched", d, 32'h1111_1401);
   endtask

   task automatic t_va_inv();
      fill(VA_A, 32'h5555_5000, 32'h6666_6660);
      va_inv_en = 1'b1; va_inv_addr = VA_A2;
      tick();
      va_inv_en = 1'b0;
      look(VA_A);
      chk("R6 tag mismatch keeps entry", 32'(lk_hit), 1);
      va_inv_en = 1'b1; va_inv_addr = VA_A | 32'h0001_FFFC;
      tick();
      va_inv_en = 1'b0;
      look(VA_A);
      chk("R6 tag match invalidates", 32'(lk_hit), 0);
      look(VA_B);
      chk("R6 other slot untouched", 32'(lk_hit), 1);
   endtask

   task automatic t_flush();
      fill(VA_A, 32'h7777_7000, 32'h8888_8880);
      fill(VA_B, 32'h9999_9000, 32'hAAAA_AAA0);
      flush_all = 1'b1;
      tick();
      flush_all = 1'b0;
      look(VA_A);
      chk("R7 flush clears slot 9", 32'(lk_hit), 0);
      look(VA_B);
      chk("R7 flush clears slot 18", 32'(lk_hit), 0);
   endtask

   task automatic t_collide();
      fill(VA_B, 32'h0BAD_0000, 32'h0BAD_0000);
      flush_all = 1'b1;
      fill(VA_A, 32'hC0DE_0000, 32'hFEED_0000);
      flush_all = 1'b0;
      look(VA_A);
      chk("R8 fill beats flush", 32'(lk_hit), 1);
      chk("R8 filled high word", lk_hi, 32'hFEED_0001);
      look(VA_B);
      chk("R8 flush still clears others", 32'(lk_hit), 0);
      sec_inv_en = 1'b1; sec_inv_num = 2'd1;
      fill(VA_A, 32'hC0DE_1000, 32'hFEED_1000);
      sec_inv_en = 1'b0;
      look(VA_A);
      chk("R8 fill beats section invalidate", 32'(lk_hit), 1);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(4'h0, slot_of(VA_B), 32'h5555_5800);
      wr(4'h1, slot_of(VA_B), 32'hCAFE_0001);
      look(VA_B);
      chk("R9 written entry hits", 32'(lk_hit), 1);
      chk("R9 written low word", lk_lo, 32'h5555_5800);
      chk("R9 written high word", lk_hi, 32'hCAFE_0001);
      wr(4'h2, slot_of(VA_B), 32'hFFFF_FFFF);
      rd(4'h2, slot_of(VA_B), d);
      chk("R9 unused entity reads zero", d, 0);
      rd(4'h0, slot_of(VA_B), d);
      chk("R9 unused entity write ignored (low)", d, 32'h5555_5800);
      rd(4'h1, slot_of(VA_B), d);
      chk("R9 unused entity write ignored (high)", d, 32'hCAFE_0001);
      flush_all = 1'b1;
      wr(4'h1, slot_of(VA_B), 32'hBEEF_0001);
      flush_all = 1'b0;
      look(VA_B);
      chk("R9 register write beats flush", 32'(lk_hit), 1);
      look(VA_A);
      chk("R9 flush applied elsewhere", 32'(lk_hit), 0);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill_hit();
      t_section();
      t_va_inv();
      t_flush();
      t_collide();
      t_regs();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule